// File: doc/BRIEF.md
# Stream Filter Oversize Blocker

This block is the per-stream filtering stage that runs ahead of a stream gate in an ingress pipeline. Each arriving frame carries an ingress service index and a length. The service index selects, through a lookup table, a stream filter entry and a flow meter index. The filter entry supplies three things: the stream gate index that the frame is handed to, a maximum service data unit (SDU) size, and an oversize-blocking control.

For every frame the block returns a verdict one cycle later: pass or drop, whether the length check failed, whether the filter was already blocked, and the selected filter, gate and flow meter indices. If a filter has oversize blocking enabled, the first oversize frame on it latches a sticky blocked state. From then on every frame on that filter is dropped until software clears the state. Software programs both tables and clears blocked states through a single write port. Each write changes exactly one field.

Top module: `sof_filter`

## Requirements
- R1: A write with `cfg_op_i`=0 stores `cfg_wdata_i[SF_W-1:0]` as the filter index of service index `cfg_addr_i`. Frames on that service index report this value on `res_sfid_o` and are judged against that filter entry.
- R2: A write with `cfg_op_i`=1 stores `cfg_wdata_i[FM_W-1:0]` as the flow meter index of service index `cfg_addr_i`, reported on `res_fmid_o`. The two per-index fields are independent, so writing one leaves the other unchanged.
- R3: Filter entry fields are written one at a time: op 2 writes the gate index, op 3 writes the maximum SDU, and op 4 writes the oversize-block enable from bit 0. Each such write leaves the other fields of that entry, including its blocked state, unchanged.
- R4: With a nonzero maximum SDU, a frame whose length is greater than the maximum is dropped and flagged on `res_oversize_o`. A frame whose length equals the maximum passes.
- R5: A maximum SDU of zero disables the length check, so any length passes on an unblocked filter.
- R6: An oversize frame on a filter whose enable is set latches that filter's blocked state at the same edge as its verdict. Every later frame on that filter is then dropped with `res_blocked_o`=1, whatever its length. An oversize frame with the enable clear does not latch the state, and other filters are unaffected.
- R7: Op 5 clears the blocked state of filter `cfg_addr_i`. Op 6 sets every field of that filter to zero, including its enable and its blocked state. Either write overrides a latch by a frame in the same cycle.
- R8: A frame presented with `frm_valid_i` yields exactly one result on the next cycle. The result carries the filter's gate index and `res_pass_o`=1 when the filter is neither blocked nor failing the length check. A frame in the same cycle as a write is judged on the contents from before the write.
- R9: After reset all table fields and blocked states are zero and `res_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 3 | Write operation code (0..6, see requirements) |
| cfg_addr_i | input | ADDR_W | Service index or filter index targeted by the write |
| cfg_wdata_i | input | CFG_DW | Write data |
| frm_valid_i | input | 1 | Frame descriptor valid |
| frm_isdx_i | input | ISDX_W | Ingress service index of the frame |
| frm_len_i | input | LEN_W | Frame length in bytes |
| res_valid_o | output | 1 | Verdict valid |
| res_pass_o | output | 1 | Frame forwarded to the gate stage |
| res_oversize_o | output | 1 | Length check failed |
| res_blocked_o | output | 1 | Filter was already in blocked state |
| res_sfid_o | output | SF_W | Selected stream filter index |
| res_gate_o | output | GATE_W | Stream gate index for the gate stage |
| res_fmid_o | output | FM_W | Selected flow meter index |

## Verification
Several rules are checked by assertions on every cycle. A frame must yield exactly one result on the next cycle. A frame that hits an already blocked filter must be dropped as blocked. The number of blocked filters may grow only through an oversize frame and may shrink only through a software write. A clear or zero write must leave its filter unblocked on the following cycle, even when a frame tries to latch it at the same edge. Other behaviour depends on values that software programmed into the tables. This covers the mapping of service indices to filters, the equal-length boundary, the zero-maximum bypass, and the fact that one field write preserves the rest of the entry. Only the bench can show these, through its scenarios and the reference model it compares against every cycle.

// File: rtl/sof_pkg.sv
package sof_pkg;
  typedef enum logic [2:0] {
    OP_MAP_SF  = 3'd0,
    OP_MAP_FM  = 3'd1,
    OP_SF_GATE = 3'd2,
    OP_SF_SDU  = 3'd3,
    OP_SF_ENA  = 3'd4,
    OP_SF_CLR  = 3'd5,
    OP_SF_ZERO = 3'd6
  } cfg_op_e;
endpackage

// File: rtl/sof_isdx_map.sv
module sof_isdx_map
  import sof_pkg::*;
#(
  parameter int NUM_ISDX = 256,
  parameter int SF_W     = 10,
  parameter int FM_W     = 12,
  parameter int CFG_DW   = 16,
  localparam int ISDX_W  = $clog2(NUM_ISDX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  cfg_op_e           op_i,
  input  logic [ISDX_W-1:0] wr_idx_i,
  input  logic [CFG_DW-1:0] wr_data_i,
  input  logic [ISDX_W-1:0] rd_idx_i,
  output logic [SF_W-1:0]   rd_sfid_o,
  output logic [FM_W-1:0]   rd_fmid_o
);
  logic [SF_W-1:0] sf_tab [NUM_ISDX];
  logic [FM_W-1:0] fm_tab [NUM_ISDX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ISDX; i++) begin
        sf_tab[i] <= '0;
        fm_tab[i] <= '0;
      end
    end else if (we_i) begin
      if (op_i == OP_MAP_SF) sf_tab[wr_idx_i] <= wr_data_i[SF_W-1:0];
      if (op_i == OP_MAP_FM) fm_tab[wr_idx_i] <= wr_data_i[FM_W-1:0];
    end
  end

  assign rd_sfid_o = sf_tab[rd_idx_i];
  assign rd_fmid_o = fm_tab[rd_idx_i];
endmodule

// File: rtl/sof_filter_table.sv
module sof_filter_table
  import sof_pkg::*;
#(
  parameter int NUM_SF = 1024,
  parameter int GATE_W = 10,
  parameter int SDU_W  = 16,
  parameter int CFG_DW = 16,
  localparam int SF_W  = $clog2(NUM_SF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  cfg_op_e           op_i,
  input  logic [SF_W-1:0]   wr_idx_i,
  input  logic [CFG_DW-1:0] wr_data_i,
  input  logic [SF_W-1:0]   rd_idx_i,
  input  logic              set_blk_i,
  output logic [GATE_W-1:0] rd_gate_o,
  output logic [SDU_W-1:0]  rd_sdu_o,
  output logic              rd_ena_o,
  output logic              rd_blk_o,
  output logic [NUM_SF-1:0] blk_vec_o
);
  logic [GATE_W-1:0] gate_q [NUM_SF];
  logic [SDU_W-1:0]  sdu_q  [NUM_SF];
  logic [NUM_SF-1:0] ena_q;
  logic [NUM_SF-1:0] blk_q;

  logic wr_zero, wr_clr;
  assign wr_zero = we_i && (op_i == OP_SF_ZERO);
  assign wr_clr  = we_i && (op_i == OP_SF_CLR);

  // field writes: one field per op, rest of entry preserved
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_SF; i++) begin
        gate_q[i] <= '0;
        sdu_q[i]  <= '0;
      end
      ena_q <= '0;
    end else if (we_i) begin
      unique case (op_i)
        OP_SF_GATE: gate_q[wr_idx_i] <= wr_data_i[GATE_W-1:0];
        OP_SF_SDU:  sdu_q[wr_idx_i]  <= wr_data_i[SDU_W-1:0];
        OP_SF_ENA:  ena_q[wr_idx_i]  <= wr_data_i[0];
        OP_SF_ZERO: begin
          gate_q[wr_idx_i] <= '0;
          sdu_q[wr_idx_i]  <= '0;
          ena_q[wr_idx_i]  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // sticky blocked state, software clear takes priority over frame set
  for (genvar g = 0; g < NUM_SF; g++) begin : g_blk
    logic sw_hit, fr_hit;
    assign sw_hit = (wr_clr || wr_zero) && (wr_idx_i == SF_W'(g));
    assign fr_hit = set_blk_i && (rd_idx_i == SF_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     blk_q[g] <= 1'b0;
      else if (sw_hit) blk_q[g] <= 1'b0;
      else if (fr_hit) blk_q[g] <= 1'b1;
    end
  end

  assign rd_gate_o = gate_q[rd_idx_i];
  assign rd_sdu_o  = sdu_q[rd_idx_i];
  assign rd_ena_o  = ena_q[rd_idx_i];
  assign rd_blk_o  = blk_q[rd_idx_i];
  assign blk_vec_o = blk_q;
endmodule

// File: rtl/sof_verdict.sv
module sof_verdict #(
  parameter int SDU_W = 16,
  parameter int LEN_W = 16,
  localparam int CMP_W = (SDU_W > LEN_W) ? SDU_W : LEN_W
) (
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [SDU_W-1:0] max_sdu_i,
  input  logic             ena_i,
  input  logic             blk_i,
  output logic             oversize_o,
  output logic             pass_o,
  output logic             set_blk_o
);
  logic [CMP_W-1:0] len_x, max_x;
  assign len_x = CMP_W'(len_i);
  assign max_x = CMP_W'(max_sdu_i);

  // zero limit means no length check
  assign oversize_o = (max_x != '0) && (len_x > max_x);
  assign pass_o     = !blk_i && !oversize_o;
  assign set_blk_o  = valid_i && oversize_o && ena_i;
endmodule

// File: rtl/sof_filter.sv
module sof_filter
  import sof_pkg::*;
#(
  parameter int NUM_ISDX = 256,
  parameter int NUM_SF   = 1024,
  parameter int NUM_SG   = 1024,
  parameter int NUM_FM   = 4096,
  parameter int SDU_W    = 16,
  parameter int LEN_W    = 16,
  parameter int CFG_DW   = 16,
  localparam int ISDX_W  = $clog2(NUM_ISDX),
  localparam int SF_W    = $clog2(NUM_SF),
  localparam int GATE_W  = $clog2(NUM_SG),
  localparam int FM_W    = $clog2(NUM_FM),
  localparam int ADDR_W  = (ISDX_W > SF_W) ? ISDX_W : SF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_op_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  input  logic              frm_valid_i,
  input  logic [ISDX_W-1:0] frm_isdx_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  output logic              res_valid_o,
  output logic              res_pass_o,
  output logic              res_oversize_o,
  output logic              res_blocked_o,
  output logic [SF_W-1:0]   res_sfid_o,
  output logic [GATE_W-1:0] res_gate_o,
  output logic [FM_W-1:0]   res_fmid_o
);
  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op_i);

  logic [SF_W-1:0]   frm_sfid;
  logic [FM_W-1:0]   frm_fmid;
  logic [GATE_W-1:0] flt_gate;
  logic [SDU_W-1:0]  flt_sdu;
  logic              flt_ena, flt_blk;
  logic [NUM_SF-1:0] blk_state;
  logic              v_ovs, v_pass, v_set;

  sof_isdx_map #(
    .NUM_ISDX(NUM_ISDX), .SF_W(SF_W), .FM_W(FM_W), .CFG_DW(CFG_DW)
  ) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .op_i      (op),
    .wr_idx_i  (cfg_addr_i[ISDX_W-1:0]),
    .wr_data_i (cfg_wdata_i),
    .rd_idx_i  (frm_isdx_i),
    .rd_sfid_o (frm_sfid),
    .rd_fmid_o (frm_fmid)
  );

  sof_filter_table #(
    .NUM_SF(NUM_SF), .GATE_W(GATE_W), .SDU_W(SDU_W), .CFG_DW(CFG_DW)
  ) u_tab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .op_i      (op),
    .wr_idx_i  (cfg_addr_i[SF_W-1:0]),
    .wr_data_i (cfg_wdata_i),
    .rd_idx_i  (frm_sfid),
    .set_blk_i (v_set),
    .rd_gate_o (flt_gate),
    .rd_sdu_o  (flt_sdu),
    .rd_ena_o  (flt_ena),
    .rd_blk_o  (flt_blk),
    .blk_vec_o (blk_state)
  );

  sof_verdict #(.SDU_W(SDU_W), .LEN_W(LEN_W)) u_vrd (
    .valid_i    (frm_valid_i),
    .len_i      (frm_len_i),
    .max_sdu_i  (flt_sdu),
    .ena_i      (flt_ena),
    .blk_i      (flt_blk),
    .oversize_o (v_ovs),
    .pass_o     (v_pass),
    .set_blk_o  (v_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o    <= 1'b0;
      res_pass_o     <= 1'b0;
      res_oversize_o <= 1'b0;
      res_blocked_o  <= 1'b0;
      res_sfid_o     <= '0;
      res_gate_o     <= '0;
      res_fmid_o     <= '0;
    end else begin
      res_valid_o <= frm_valid_i;
      if (frm_valid_i) begin
        res_pass_o     <= v_pass;
        res_oversize_o <= v_ovs;
        res_blocked_o  <= flt_blk;
        res_sfid_o     <= frm_sfid;
        res_gate_o     <= flt_gate;
        res_fmid_o     <= frm_fmid;
      end
    end
  end
endmodule

// File: rtl/sof_filter_chk.sv
module sof_filter_chk #(
  parameter int NUM_SF = 1024,
  parameter int ADDR_W = 10,
  localparam int SF_W  = $clog2(NUM_SF)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [2:0]        cfg_op_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic              frm_valid_i,
  input logic [SF_W-1:0]   frm_sfid,
  input logic [NUM_SF-1:0] blk_state,
  input logic              res_valid_o,
  input logic              res_pass_o,
  input logic              res_oversize_o,
  input logic              res_blocked_o
);
  logic [SF_W-1:0] addr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= cfg_addr_i[SF_W-1:0];
  end

  // R8
  res_follows_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |=> res_valid_o);
  // R8
  no_spurious_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_valid_i |=> !res_valid_o);
  // R6
  blocked_hit_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_i && blk_state[frm_sfid]) |=> (res_blocked_o && !res_pass_o));
  // R6
  blocked_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($countones(blk_state) >= $past($countones(blk_state))));
  // R6
  blocked_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(blk_state) > $past($countones(blk_state))) |-> res_oversize_o);
  // R7
  sw_clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (cfg_op_i == 3'd5 || cfg_op_i == 3'd6)) |=> !blk_state[addr_q]);
  // R4
  oversize_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_oversize_o) |-> !res_pass_o);
endmodule

bind sof_filter sof_filter_chk #(.NUM_SF(NUM_SF), .ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_we_i       (cfg_we_i),
  .cfg_op_i       (cfg_op_i),
  .cfg_addr_i     (cfg_addr_i),
  .frm_valid_i    (frm_valid_i),
  .frm_sfid       (frm_sfid),
  .blk_state      (blk_state),
  .res_valid_o    (res_valid_o),
  .res_pass_o     (res_pass_o),
  .res_oversize_o (res_oversize_o),
  .res_blocked_o  (res_blocked_o)
);

// File: tb/sof_filter_test.sv
module sof_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_op = '0;
  logic [9:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic [7:0]  frm_isdx = '0;
  logic [15:0] frm_len = '0;
  logic        res_valid, res_pass, res_ovs, res_blk;
  logic [9:0]  res_sfid, res_gate;
  logic [11:0] res_fmid;

  always #2 clk = ~clk;

  sof_filter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_op_i(cfg_op), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .frm_valid_i(frm_valid), .frm_isdx_i(frm_isdx), .frm_len_i(frm_len),
    .res_valid_o(res_valid), .res_pass_o(res_pass), .res_oversize_o(res_ovs),
    .res_blocked_o(res_blk), .res_sfid_o(res_sfid), .res_gate_o(res_gate),
    .res_fmid_o(res_fmid)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_sf[256], m_fm[256], m_gate[1024], m_sdu[1024];
  bit m_ena[1024], m_blk[1024];
  bit e_valid, e_pass, e_ovs, e_blk;
  int e_sf, e_gate, e_fm;
  string e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_sf[i]) begin m_sf[i] = 0; m_fm[i] = 0; end
      foreach (m_gate[i]) begin m_gate[i] = 0; m_sdu[i] = 0; m_ena[i] = 0; m_blk[i] = 0; end
      e_valid = 0;
    end else begin
      e_valid = frm_valid;
      if (frm_valid) begin
        int s;
        s      = m_sf[frm_isdx];
        e_sf   = s;
        e_fm   = m_fm[frm_isdx];
        e_gate = m_gate[s];
        e_ovs  = (m_sdu[s] != 0) && (int'(frm_len) > m_sdu[s]);
        e_blk  = m_blk[s];
        e_pass = !e_blk && !e_ovs;
        e_tag  = e_blk ? "R6" : (m_sdu[s] == 0 ? "R5" : "R4");
        if (e_ovs && m_ena[s]) m_blk[s] = 1;
      end
      if (cfg_we) begin
        case (cfg_op)
          3'd0: m_sf[cfg_addr & 255] = cfg_wdata & 1023;
          3'd1: m_fm[cfg_addr & 255] = cfg_wdata & 4095;
          3'd2: m_gate[cfg_addr] = cfg_wdata & 1023;
          3'd3: m_sdu[cfg_addr] = cfg_wdata;
          3'd4: m_ena[cfg_addr] = cfg_wdata[0];
          3'd5: m_blk[cfg_addr] = 0;
          3'd6: begin
            m_gate[cfg_addr] = 0; m_sdu[cfg_addr] = 0;
            m_ena[cfg_addr] = 0; m_blk[cfg_addr] = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(res_valid == e_valid, "R8 valid", res_valid, e_valid);
      if (e_valid) begin
        chk(res_pass == e_pass, e_tag, res_pass, e_pass);
        chk(res_ovs == e_ovs, "R4 oversize", res_ovs, e_ovs);
        chk(res_blk == e_blk, "R6 blocked", res_blk, e_blk);
        chk(int'(res_sfid) == e_sf, "R1 sfid", res_sfid, e_sf);
        chk(int'(res_gate) == e_gate, "R8 gate", res_gate, e_gate);
        chk(int'(res_fmid) == e_fm, "R2 fmid", res_fmid, e_fm);
      end
    end
  end

  task automatic cyc(input bit we, input int op, input int addr, input int data,
                     input bit fv, input int isdx, input int len);
    @(negedge clk);
    cfg_we = we; cfg_op = 3'(op); cfg_addr = 10'(addr); cfg_wdata = 16'(data);
    frm_valid = fv; frm_isdx = 8'(isdx); frm_len = 16'(len);
  endtask

  task automatic wr(input int op, input int addr, input int data);
    cyc(1, op, addr, data, 0, 0, 0);
  endtask

  task automatic frm(input int isdx, input int len);
    cyc(0, 0, 0, 0, 1, isdx, len);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(res_valid == 1'b0, "R9 reset valid", res_valid, 0);
    rst_n = 1'b1;
    frm(4, 9000);              // R9: zero tables -> sf 0, limit 0, gate 0, pass
    idle(); #1;
    chk(res_pass && res_gate == 0 && res_sfid == 0, "R9 zero tables", res_pass, 1);

    // R1/R2 mapping, R4 boundary
    wr(0, 3, 5); wr(1, 3, 77);
    wr(2, 5, 9); wr(3, 5, 100);
    frm(3, 100); frm(3, 101); frm(3, 50);
    idle(); #1;
    chk(res_pass == 1 && res_gate == 9, "R4 under limit", res_pass, 1);
    wr(1, 3, 78);              // R2: fm write keeps sf map
    frm(3, 10); idle(); #1;
    chk(res_sfid == 5 && res_fmid == 78, "R2 independent", res_sfid, 5);

    // R5 zero limit
    wr(0, 4, 6); wr(2, 6, 33);
    frm(4, 65535); idle(); #1;
    chk(res_pass == 1 && res_ovs == 0, "R5 zero limit", res_pass, 1);

    // R6 oversize without enable does not latch
    frm(3, 200); frm(3, 20); idle(); #1;
    chk(res_pass == 1, "R6 no enable", res_pass, 1);

    // R6 latch, then short frames dropped, other filter unaffected
    wr(4, 5, 1);
    frm(3, 200); frm(3, 10); frm(4, 10); frm(3, 0);
    idle(); #1;
    chk(res_blk == 1 && res_pass == 0, "R6 sticky", res_blk, 1);

    // R3 field write keeps blocked state and limit
    wr(2, 5, 12);
    frm(3, 100); idle(); #1;
    chk(res_blk == 1 && res_gate == 12, "R3 rmw gate", res_gate, 12);

    // R7 clear
    wr(5, 5, 0);
    frm(3, 100); idle(); #1;
    chk(res_pass == 1 && res_blk == 0, "R7 clear", res_pass, 1);

    // R7 clear in same cycle as latching frame: clear wins
    cyc(1, 5, 5, 0, 1, 3, 300);
    frm(3, 10); idle(); #1;
    chk(res_pass == 1 && res_blk == 0, "R7 clear wins", res_pass, 1);

    // R7 zero op
    frm(3, 300); wr(6, 5, 0);
    frm(3, 5000); idle(); #1;
    chk(res_pass == 1 && res_gate == 0 && res_ovs == 0, "R7 zero entry", res_gate, 0);

    // R8 frame with same-cycle write judged on old contents
    wr(3, 5, 50);
    cyc(1, 3, 5, 0, 1, 3, 60);
    idle(); #1;
    chk(res_ovs == 1, "R8 pre-write view", res_ovs, 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op, r;
      r  = $urandom_range(0, 9);
      op = $urandom_range(0, 6);
      cyc(r < 4, op, $urandom_range(0, 7),
          (op <= 1) ? $urandom_range(0, 7) : $urandom_range(0, 150),
          r >= 2, $urandom_range(0, 7), $urandom_range(0, 200));
    end
    idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule